// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual address into a physical address by reading a hierarchical page table held in memory. A request carries a 64-bit virtual address, an access type (read or write) and a mode select. It is paired with a root table base. The walker then fetches one table entry per level through a read port that allows a single outstanding request. Each entry is checked as it arrives. When the walk ends, the walker reports the physical address, or a fault code with the level that failed, in a one-cycle done pulse.

Two layouts are supported. The 64-bit layout has four levels of 9-bit indexes and 8-byte entries, and it requires the address to be correctly sign-extended. The 32-bit layout has two levels of 10-bit indexes and 4-byte entries. Both layouts use 4 KiB pages. The walker holds no translations between requests, so every request walks the tables from the root.

Top module: `ptw_walker`

## Requirements
- R1: In 64-bit mode (req_legacy=0), the first read is at the root base, with root_base bits [11:0] treated as zero, plus 8 times VA[47:39]. Later reads are at the current table base plus 8 times VA[38:30], then VA[29:21], then VA[20:12]. mem_rd_wide is 1 and every read address is a multiple of 8.
- R2: In 64-bit mode a walk with no fault makes exactly four reads, from the top level down to the last level. The base for the next level is entry bits [51:12] shifted left by 12. Entry bits [63:52] and [11:2] have no effect.
- R3: A walk that completes reports done_fault=0 (none) and done_level=0. done_paddr is the final frame base concatenated with VA[11:0].
- R4: In 64-bit mode, if VA[63:48] is not 16 copies of VA[47], no read is issued. done rises in the cycle after the request is accepted, with done_fault=1 (non-canonical) and done_level=0.
- R5: In 32-bit mode (req_legacy=1), reads are 4 bytes (mem_rd_wide=0). The first read is at root_base, with bits [11:0] and bits above 31 treated as zero, plus 4 times VA[31:22]. The second read is at the next base plus 4 times VA[21:12], and the next base is entry bits [31:12] shifted left by 12. VA[63:32] and mem_rsp_data[63:32] are ignored, no canonical check is made, and done_paddr bits above 31 are zero.
- R6: When entry bit 0 (present) is clear, the walk stops after that read and reports done_fault=2 (not present). done_level is the level number, counted 1 for the top level up to 4 (or 2 in 32-bit mode).
- R7: On a write access (req_write=1), an entry with bit 1 clear stops the walk with done_fault=3 (write protected) at that level number. A clear present bit takes priority at the same level. Read accesses ignore bit 1.
- R8: req_ready is 1 only while idle, so a request offered during a walk is not taken. done lasts exactly one cycle. done_paddr is 0 whenever done_fault is not 0. After reset, req_ready=1, mem_rd_valid=0 and done=0.
- R9: mem_rd_valid stays high with a stable address and width until mem_rd_ready is seen. After that handshake, no new read is issued until mem_rsp_valid arrives, which may take any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; request taken when both high |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 for write access |
| req_legacy | input | 1 | 1 selects the two-level 32-bit layout |
| root_base | input | 52 | Physical base of the top table |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 52 | Physical address of the entry |
| mem_rd_wide | output | 1 | 1 for an 8-byte read, 0 for a 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle result strobe |
| done_paddr | output | 52 | Translated physical address |
| done_fault | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 write protected |
| done_level | output | 3 | Failing level (1 = top), 0 otherwise |

## Verification
The assertions assume the memory side behaves correctly. It raises mem_rsp_valid only while a read has been accepted and not yet answered, and it returns exactly one response per read. The bench memory responder follows this. It waits a random 0 to 2 cycles before granting ready and a random 0 to 3 cycles before answering, and only after the previous read has been answered. Requests are driven only while the walker is idle. The one exception is a deliberate extra request held for one cycle after acceptance, which is there to exercise R8.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W       = 64;
    localparam int PA_W       = 52;
    localparam int PG_SH      = 12;
    localparam int IDX_W      = 9;
    localparam int LVL_N      = 4;
    localparam int ENT_W      = 64;
    localparam int ENT_SH     = 3;
    localparam int LEG_IDX_W  = 10;
    localparam int LEG_LVL_N  = 2;
    localparam int LEG_ENT_W  = 32;
    localparam int LEG_ENT_SH = 2;

    localparam int VA_KEEP  = PG_SH + IDX_W * LVL_N;
    localparam int CANON_HI = VA_KEEP - 1;
    localparam int VPN_W    = VA_KEEP - PG_SH;
    localparam int IDXM_W   = (IDX_W > LEG_IDX_W) ? IDX_W : LEG_IDX_W;
    localparam int LVL_W    = $clog2(LVL_N + 1);

    localparam logic [PA_W-1:0] PG_MASK_LONG =
        {{(PA_W - PG_SH){1'b1}}, {PG_SH{1'b0}}};
    localparam logic [PA_W-1:0] PG_MASK_LEG =
        PA_W'({{(LEG_ENT_W - PG_SH){1'b1}}, {PG_SH{1'b0}}});
    localparam logic [ENT_W-1:0] ENT_MASK_LONG = ENT_W'(PG_MASK_LONG);
    localparam logic [ENT_W-1:0] ENT_MASK_LEG  = ENT_W'(PG_MASK_LEG);

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NONCANON = 2'd1,
        FLT_ABSENT   = 2'd2,
        FLT_WRPROT   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [VA_KEEP-1:0] va;
        logic               wr;
        logic               leg;
    } walk_req_t;

    typedef struct packed {
        fault_e            kind;
        logic [PA_W-1:0]   nxt;
    } eval_res_t;

    function automatic logic is_canonical(input logic [VA_W-1:0] va);
        logic [VA_W-CANON_HI-1:0] top;
        top = va[VA_W-1:CANON_HI];
        return (&top) | (~|top);
    endfunction

    function automatic logic [PA_W-1:0] root_align(input logic [PA_W-1:0] root,
                                                   input logic leg);
        return leg ? (root & PG_MASK_LEG) : (root & PG_MASK_LONG);
    endfunction

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import ptw_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn,
    input  logic              leg,
    input  logic [LVL_W-1:0]  lvl,
    output logic [IDXM_W-1:0] idx
);

    logic [IDXM_W-1:0] long_idx [LVL_N];
    logic [IDXM_W-1:0] leg_idx  [LEG_LVL_N];

    generate
        for (genvar g = 0; g < LVL_N; g++) begin : g_long
            localparam int LO = IDX_W * (LVL_N - 1 - g);
            assign long_idx[g] = IDXM_W'(vpn[LO +: IDX_W]);
        end
        for (genvar g = 0; g < LEG_LVL_N; g++) begin : g_leg
            localparam int LO = LEG_IDX_W * (LEG_LVL_N - 1 - g);
            assign leg_idx[g] = IDXM_W'(vpn[LO +: LEG_IDX_W]);
        end
    endgenerate

    always_comb begin
        idx = '0;
        if (leg) begin
            for (int i = 0; i < LEG_LVL_N; i++)
                if (lvl == LVL_W'(i)) idx = leg_idx[i];
        end else begin
            for (int i = 0; i < LVL_N; i++)
                if (lvl == LVL_W'(i)) idx = long_idx[i];
        end
    end

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]   base,
    input  logic [IDXM_W-1:0] idx,
    input  logic              leg,
    output logic [PA_W-1:0]   addr
);

    logic [PA_W-1:0] offs;

    always_comb begin
        if (leg) offs = PA_W'(idx) << LEG_ENT_SH;
        else     offs = PA_W'(idx) << ENT_SH;
        addr = base + offs;
    end

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic             leg,
    input  logic             wr,
    output eval_res_t        res
);

    logic present;
    logic wen;

    always_comb begin
        present = entry[0];
        wen     = entry[1];
        if (!present)         res.kind = FLT_ABSENT;
        else if (wr && !wen)  res.kind = FLT_WRPROT;
        else                  res.kind = FLT_NONE;
        if (leg) res.nxt = PA_W'(entry & ENT_MASK_LEG);
        else     res.nxt = PA_W'(entry & ENT_MASK_LONG);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_legacy,
    input  logic [PA_W-1:0]   root_base,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    output logic              mem_rd_wide,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic [PA_W-1:0]   done_paddr,
    output logic [1:0]        done_fault,
    output logic [LVL_W-1:0]  done_level
);

    walk_st_e          st;
    walk_req_t         rq;
    logic [PA_W-1:0]   base;
    logic [LVL_W-1:0]  lvl;
    logic [PA_W-1:0]   res_pa;
    fault_e            res_kind;
    logic [LVL_W-1:0]  res_lvl;

    logic [IDXM_W-1:0] idx;
    logic [PA_W-1:0]   ent_addr;
    eval_res_t         ev;
    logic              last;

    ptw_index_sel u_idx (
        .vpn (rq.va[VA_KEEP-1:PG_SH]),
        .leg (rq.leg),
        .lvl (lvl),
        .idx (idx)
    );

    ptw_entry_addr u_addr (
        .base (base),
        .idx  (idx),
        .leg  (rq.leg),
        .addr (ent_addr)
    );

    ptw_entry_eval u_eval (
        .entry (mem_rsp_data),
        .leg   (rq.leg),
        .wr    (rq.wr),
        .res   (ev)
    );

    assign last = rq.leg ? (lvl == LVL_W'(LEG_LVL_N - 1))
                         : (lvl == LVL_W'(LVL_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rq       <= '0;
            base     <= '0;
            lvl      <= '0;
            res_pa   <= '0;
            res_kind <= FLT_NONE;
            res_lvl  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq.va   <= req_vaddr[VA_KEEP-1:0];
                        rq.wr   <= req_write;
                        rq.leg  <= req_legacy;
                        lvl     <= '0;
                        base    <= root_align(root_base, req_legacy);
                        res_pa  <= '0;
                        res_lvl <= '0;
                        if (!req_legacy && !is_canonical(req_vaddr)) begin
                            res_kind <= FLT_NONCANON;
                            st       <= ST_DONE;
                        end else begin
                            res_kind <= FLT_NONE;
                            st       <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_rd_ready) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ev.kind != FLT_NONE) begin
                            res_kind <= ev.kind;
                            res_lvl  <= lvl + 1'b1;
                            res_pa   <= '0;
                            st       <= ST_DONE;
                        end else if (last) begin
                            res_kind <= FLT_NONE;
                            res_lvl  <= '0;
                            res_pa   <= {ev.nxt[PA_W-1:PG_SH], rq.va[PG_SH-1:0]};
                            st       <= ST_DONE;
                        end else begin
                            base <= ev.nxt;
                            lvl  <= lvl + 1'b1;
                            st   <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == ST_IDLE);
    assign mem_rd_valid = (st == ST_ISSUE);
    assign mem_rd_addr  = ent_addr;
    assign mem_rd_wide  = !rq.leg;
    assign done         = (st == ST_DONE);
    assign done_paddr   = res_pa;
    assign done_fault   = res_kind;
    assign done_level   = res_lvl;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              req_legacy,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [PA_W-1:0]   mem_rd_addr,
    input logic              mem_rd_wide,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic [PA_W-1:0]   done_paddr,
    input logic [1:0]        done_fault,
    input logic [LVL_W-1:0]  done_level
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst)                               pend <= 1'b0;
        else if (mem_rd_valid && mem_rd_ready) pend <= 1'b1;
        else if (mem_rsp_valid)                pend <= 1'b0;
    end

    // R9: request held with stable address until accepted
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=>
            mem_rd_valid && $stable(mem_rd_addr) && $stable(mem_rd_wide));

    // R9: never a second read while one is outstanding
    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        pend |-> !mem_rd_valid);

    // R8: done is a single-cycle strobe
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: idle walker neither reads nor reports
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_valid && !done);

    // R8: faulted results carry a zero address
    a_r8_fault_pa: assert property (@(posedge clk) disable iff (rst)
        done && done_fault != 2'd0 |-> done_paddr == '0);

    // R4: non-canonical request reported in the next cycle
    a_r4_noncanon: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !req_legacy &&
        (req_vaddr[VA_W-1:CANON_HI] != {(VA_W-CANON_HI){req_vaddr[CANON_HI]}})
        |=> done && done_fault == 2'd1 && done_level == '0);

    // R1, R5: entry addresses aligned to entry size
    a_r1_align: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (mem_rd_wide ? (mem_rd_addr[2:0] == 3'd0)
                                      : (mem_rd_addr[1:0] == 2'd0)));

    // R6, R7: permission faults name a real level
    a_r6_level: assert property (@(posedge clk) disable iff (rst)
        done && done_fault[1] |-> done_level >= LVL_W'(1) && done_level <= LVL_W'(LVL_N));

endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_legacy    (req_legacy),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_wide   (mem_rd_wide),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .done_paddr    (done_paddr),
    .done_fault    (done_fault),
    .done_level    (done_level)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_vaddr;
    logic        req_write;
    logic        req_legacy;
    logic [51:0] root_base;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [51:0] mem_rd_addr;
    logic        mem_rd_wide;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic [51:0] done_paddr;
    logic [1:0]  done_fault;
    logic [2:0]  done_level;

    ptw_walker u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_legacy(req_legacy), .root_base(root_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rd_wide(mem_rd_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
        .done_level(done_level)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] mem [logic [51:0]];

    logic [51:0] got_addr [8];
    logic        got_wide [8];
    int          got_n;
    int          viol;

    logic [51:0] e_pa;
    int          e_kind;
    int          e_lvl;
    int          e_n;
    logic [51:0] e_addr [4];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // memory responder
    initial begin
        logic [51:0] a;
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                a = mem_rd_addr;
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    if (!mem_rd_valid || mem_rd_addr != a) viol++;
                end
                mem_rd_ready = 1'b1;
                if (got_n < 8) begin
                    got_addr[got_n] = mem_rd_addr;
                    got_wide[got_n] = mem_rd_wide;
                end
                got_n++;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                repeat ($urandom_range(0, 3)) begin
                    if (mem_rd_valid) viol++;
                    @(negedge clk);
                end
                if (mem_rd_valid) viol++;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = {$urandom, $urandom};
            end
        end
    end

    function automatic logic [51:0] base_of(input logic [51:0] r, input bit leg);
        return leg ? {20'h0, r[31:12], 12'h0} : {r[51:12], 12'h0};
    endfunction

    function automatic logic [9:0] idx_of(input logic [63:0] va, input bit leg, input int l);
        if (leg) return (l == 0) ? va[31:22] : va[21:12];
        return {1'b0, va[47 - 9*l -: 9]};
    endfunction

    // reference walk from the requirements
    task automatic ref_walk(input logic [63:0] va, input bit wr, input bit leg,
                            input logic [51:0] root);
        logic [51:0] b;
        logic [63:0] e;
        int nl;
        b = base_of(root, leg);
        nl = leg ? 2 : 4;
        e_pa = '0; e_kind = 0; e_lvl = 0; e_n = 0;
        if (!leg && va[63:48] != {16{va[47]}}) begin
            e_kind = 1;
            return;
        end
        for (int l = 0; l < nl; l++) begin
            e_addr[l] = b + (52'(idx_of(va, leg, l)) << (leg ? 2 : 3));
            e_n++;
            e = mem.exists(e_addr[l]) ? mem[e_addr[l]] : 64'h0;
            if (leg) e = {32'h0, e[31:0]};
            if (!e[0])            begin e_kind = 2; e_lvl = l + 1; return; end
            if (wr && !e[1])      begin e_kind = 3; e_lvl = l + 1; return; end
            b = leg ? {20'h0, e[31:12], 12'h0} : {e[51:12], 12'h0};
        end
        e_pa = {b[51:12], va[11:0]};
    endtask

    // inj_kind: 0 none, 1 clear present, 2 clear write, 3 clear both
    task automatic build(input logic [63:0] va, input bit leg, input logic [51:0] root,
                         input int inj_lvl, input int inj_kind);
        logic [51:0] b;
        logic [51:0] a;
        logic [63:0] e;
        logic [39:0] fr;
        int nl;
        mem.delete();
        b = base_of(root, leg);
        nl = leg ? 2 : 4;
        for (int l = 0; l < nl; l++) begin
            a = b + (52'(idx_of(va, leg, l)) << (leg ? 2 : 3));
            fr = {$urandom, $urandom};
            if (leg) begin
                fr[39:20] = '0;
                e = {$urandom, fr[19:0], 10'($urandom), 2'b11};
            end else begin
                e = {12'($urandom), fr, 10'($urandom), 2'b11};
            end
            if (l == inj_lvl) begin
                if (inj_kind == 1 || inj_kind == 3) e[0] = 1'b0;
                if (inj_kind == 2 || inj_kind == 3) e[1] = 1'b0;
            end
            mem[a] = e;
            b = {fr, 12'h0};
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input bit wr, input bit leg,
                            input logic [51:0] root);
        int cnt;
        string kr;
        string ar;
        ref_walk(va, wr, leg, root);
        got_n = 0;
        viol  = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_write  = wr;
        req_legacy = leg;
        root_base  = root;
        @(negedge clk);
        chk(req_ready == 1'b0, "R8", "ready low after accept", 64'(req_ready), 64'h0);
        if (done) begin
            req_valid = 1'b0;
        end else begin
            req_vaddr = {$urandom, $urandom};
            req_write = ~wr;
            req_legacy = ~leg;
            root_base = {$urandom, $urandom};
        end
        cnt = 0;
        while (!done && cnt < 400) begin
            @(negedge clk);
            req_valid = 1'b0;
            cnt++;
        end
        case (e_kind)
            1: kr = "R4";
            2: kr = "R6";
            3: kr = "R7";
            default: kr = "R3";
        endcase
        ar = leg ? "R5" : "R1";
        chk(done == 1'b1, "R8", "done seen", 64'(done), 64'h1);
        if (e_kind == 1)
            chk(cnt == 0, "R4", "done cycle", 64'(cnt), 64'h0);
        chk(done_fault == 2'(e_kind), kr, "fault", 64'(done_fault), 64'(e_kind));
        chk(done_level == 3'(e_lvl), kr, "level", 64'(done_level), 64'(e_lvl));
        chk(done_paddr == e_pa, leg ? "R5" : "R3", "paddr", 64'(done_paddr), 64'(e_pa));
        chk(got_n == e_n, "R2", "read count", 64'(got_n), 64'(e_n));
        for (int i = 0; i < e_n && i < got_n && i < 8; i++) begin
            chk(got_addr[i] == e_addr[i], ar, "entry addr", 64'(got_addr[i]), 64'(e_addr[i]));
            chk(got_wide[i] == !leg, ar, "read width", 64'(got_wide[i]), 64'(!leg));
        end
        chk(viol == 0, "R9", "handshake", 64'(viol), 64'h0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", 64'(done), 64'h0);
        chk(req_ready == 1'b1, "R8", "ready after done", 64'(req_ready), 64'h1);
    endtask

    initial begin
        logic [63:0] va;
        logic [51:0] rt;
        void'($urandom(32'd20240611));
        got_n = 0;
        viol = 0;
        rst = 1'b1;
        req_valid = 1'b0;
        req_vaddr = '0;
        req_write = 1'b0;
        req_legacy = 1'b0;
        root_base = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "reset ready", 64'(req_ready), 64'h1);
        chk(mem_rd_valid == 1'b0, "R8", "reset rd_valid", 64'(mem_rd_valid), 64'h0);
        chk(done == 1'b0, "R8", "reset done", 64'(done), 64'h0);

        // R1 R2 R3: directed canonical corners
        rt = 52'h0_1234_5678_9abc;
        build(64'h0, 0, rt, -1, 0);
        run_walk(64'h0, 0, 0, rt);
        va = 64'h0000_7fff_ffff_ffff;
        build(va, 0, rt, -1, 0);
        run_walk(va, 1, 0, rt);
        va = 64'hffff_8000_0000_0123;
        build(va, 0, rt, -1, 0);
        run_walk(va, 0, 0, rt);

        // R4: non-canonical
        run_walk(64'h0000_8000_0000_0000, 0, 0, rt);
        run_walk(64'h8000_0000_0000_1000, 1, 0, rt);
        run_walk(64'hfffe_ffff_ffff_f000, 0, 0, rt);

        // R6: empty memory, fault at top level
        mem.delete();
        run_walk(64'h0000_1234_5678_9000, 0, 0, rt);

        // R7: write-protect at last level, read passes on same tables
        va = 64'h0000_00ab_cdef_0456;
        build(va, 0, rt, 3, 2);
        run_walk(va, 1, 0, rt);
        run_walk(va, 0, 0, rt);
        // R7: present takes priority over write
        build(va, 0, rt, 2, 3);
        run_walk(va, 1, 0, rt);

        // R5: legacy with junk upper address and root bits
        va = 64'hdead_beef_8765_4321;
        rt = 52'hf_ffff_1234_5abc;
        build(va, 1, rt, -1, 0);
        run_walk(va, 1, 1, rt);
        build(va, 1, rt, 1, 1);
        run_walk(va, 0, 1, rt);

        // random mix
        for (int t = 0; t < 300; t++) begin
            bit leg;
            bit wr;
            int il;
            int ik;
            leg = ($urandom_range(0, 3) == 0);
            wr  = $urandom_range(0, 1);
            va  = {$urandom, $urandom};
            if (!leg && $urandom_range(0, 9) != 0) va[63:48] = {16{va[47]}};
            rt  = {$urandom, $urandom};
            il  = $urandom_range(0, leg ? 1 : 3);
            ik  = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 3) : 0;
            build(va, leg, rt, il, ik);
            run_walk(va, wr, leg, rt);
        end

        finish_run();
    end

endmodule